// File: doc/BRIEF.md
# Mailbox Doorbell Interrupt Unit

This block passes short messages and interrupt requests between a local CPU and an agent on a host bus. Each side has its own simple synchronous register port, with a write strobe, a word address, write data and combinational read data. Both ports see the same word address map. What a write does depends on the side it comes from. The unit holds two message words in each direction and one doorbell word in each direction. It also has an event (cause) word and a mask word for each direction.

A message or doorbell written by one side raises an event bit that only the other side can clear. The CPU-facing interrupt is computed from the inbound events and the inbound mask. The host-facing interrupt is computed from the outbound events and the outbound mask. Each interrupt is a registered OR of the unmasked event bits. The doorbell event is the OR of all bits of its doorbell word, so it stays high until the receiving side has cleared every bit. A separate pulse input reports an inbound post-queue event.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset, the message words, doorbell words and event words read zero, both mask words (addresses 7 and 9) read all ones, and both interrupt outputs are low.
- R2: A host write to address 0 or 1 stores the data in inbound message 0 or 1. In the same edge it sets inbound event bit 0 or 1. A CPU write to these addresses changes nothing.
- R3: A CPU write to address 2 or 3 stores the data in outbound message 0 or 1. In the same edge it sets outbound event bit 0 or 1. A host write to these addresses changes nothing.
- R4: A CPU write to address 6 clears each inbound event bit (0, 1, 4) whose data bit is 1 and leaves the others unchanged. A host write to address 8 does the same for outbound event bits 0 and 1. Writes from the other side to either event word have no effect.
- R5: A CPU write to address 5 sets every outbound doorbell bit that is 1 in the data. A host write to address 5 clears every bit that is 1 in the data. If both hit the same bit in one cycle, the bit ends up set.
- R6: A host write to address 4 sets inbound doorbell bits, and a CPU write to address 4 clears them. If both hit the same bit in one cycle, the bit ends up set.
- R7: Bit 2 of each event word reads 1 exactly while its doorbell word (inbound for address 6, outbound for address 8) is nonzero. Writing the event word cannot clear it.
- R8: A pulse on `post_evt` sets inbound event bit 4. If the CPU clears bit 4 in the same cycle, the bit ends up set.
- R9: Only the CPU writes the mask words (7 inbound, 9 outbound), and host writes to them are ignored. A mask bit at 1 keeps its event bit from the interrupt, while the event bit still latches and reads back.
- R10: `cpu_irq` is the OR of the inbound event bits with mask 0, taken one clock later. `host_irq` is the same for the outbound word.
- R11: Reads from addresses 10 to 15 return zero on both ports.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | ADDR_W | CPU word address (read and write) |
| cpu_wdata | input | DATA_W | CPU write data |
| cpu_rdata | output | DATA_W | CPU read data for cpu_addr |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host word address (read and write) |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data for host_addr |
| post_evt | input | 1 | Inbound post-queue event pulse |
| cpu_irq | output | 1 | Interrupt toward the CPU |
| host_irq | output | 1 | Interrupt toward the host agent |

## Verification
The bench builds the unit with a 32-bit data path and a 4-bit address. This lets it drive a doorbell's top bit on its own, and it leaves six undecoded addresses whose reads must return zero. The 4-bit address also lets random traffic reach every decoded word from both sides at once. That traffic includes same-cycle set and clear collisions on doorbell and event bits, and mask writes that land in the same cycle as event changes.

// File: rtl/mbox_doorbell.sv
`timescale 1ns/1ps
module mbox_doorbell #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              post_evt,
  output logic              cpu_irq,
  output logic              host_irq
);
  localparam logic [ADDR_W-1:0] A_IMSG0 = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_IMSG1 = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_OMSG0 = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_OMSG1 = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_IDB   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_ODB   = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_IEVT  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_IMSK  = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_OEVT  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_OMSK  = ADDR_W'(9);
  localparam int B_DB = 2;
  localparam int B_POST = 4;
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);
  localparam logic [DATA_W-1:0] IN_EVT  = ONE | (ONE << 1) | (ONE << B_POST);
  localparam logic [DATA_W-1:0] OUT_EVT = ONE | (ONE << 1);

  logic [1:0][DATA_W-1:0] in_msg, out_msg;
  logic [DATA_W-1:0] in_db, out_db, in_cause_q, out_cause_q, in_mask, out_mask;
  logic [DATA_W-1:0] in_set, in_clr, out_set, out_clr, in_view, out_view;
  logic [1:0] hw_im, cw_om;

  assign hw_im[0] = host_we && host_addr == A_IMSG0;
  assign hw_im[1] = host_we && host_addr == A_IMSG1;
  assign cw_om[0] = cpu_we && cpu_addr == A_OMSG0;
  assign cw_om[1] = cpu_we && cpu_addr == A_OMSG1;

  always_comb begin
    in_set = '0;
    in_set[0] = hw_im[0];
    in_set[1] = hw_im[1];
    in_set[B_POST] = post_evt;
    out_set = '0;
    out_set[0] = cw_om[0];
    out_set[1] = cw_om[1];
    in_clr  = (cpu_we && cpu_addr == A_IEVT) ? (cpu_wdata & IN_EVT) : '0;
    out_clr = (host_we && host_addr == A_OEVT) ? (host_wdata & OUT_EVT) : '0;
  end

  assign in_view  = in_cause_q  | ((|in_db)  ? (ONE << B_DB) : '0);
  assign out_view = out_cause_q | ((|out_db) ? (ONE << B_DB) : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_msg      <= '0;
      out_msg     <= '0;
      in_db       <= '0;
      out_db      <= '0;
      in_cause_q  <= '0;
      out_cause_q <= '0;
      in_mask     <= '1;
      out_mask    <= '1;
      cpu_irq     <= 1'b0;
      host_irq    <= 1'b0;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (hw_im[i]) in_msg[i]  <= host_wdata;
        if (cw_om[i]) out_msg[i] <= cpu_wdata;
      end
      in_db  <= (in_db  & ~((cpu_we  && cpu_addr  == A_IDB) ? cpu_wdata  : '0))
              | ((host_we && host_addr == A_IDB) ? host_wdata : '0);
      out_db <= (out_db & ~((host_we && host_addr == A_ODB) ? host_wdata : '0))
              | ((cpu_we  && cpu_addr  == A_ODB) ? cpu_wdata  : '0);
      in_cause_q  <= (in_cause_q  & ~in_clr)  | in_set;
      out_cause_q <= (out_cause_q & ~out_clr) | out_set;
      if (cpu_we && cpu_addr == A_IMSK) in_mask  <= cpu_wdata;
      if (cpu_we && cpu_addr == A_OMSK) out_mask <= cpu_wdata;
      cpu_irq  <= |(in_view  & ~in_mask);
      host_irq <= |(out_view & ~out_mask);
    end
  end

  function automatic logic [DATA_W-1:0] rd_sel(input logic [ADDR_W-1:0] a);
    case (a)
      A_IMSG0: return in_msg[0];
      A_IMSG1: return in_msg[1];
      A_OMSG0: return out_msg[0];
      A_OMSG1: return out_msg[1];
      A_IDB:   return in_db;
      A_ODB:   return out_db;
      A_IEVT:  return in_view;
      A_IMSK:  return in_mask;
      A_OEVT:  return out_view;
      A_OMSK:  return out_mask;
      default: return '0;
    endcase
  endfunction

  assign cpu_rdata  = rd_sel(cpu_addr);
  assign host_rdata = rd_sel(host_addr);
endmodule

// File: rtl/mbox_doorbell_chk.sv
`timescale 1ns/1ps
module mbox_doorbell_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              host_we,
  input logic [ADDR_W-1:0] host_addr,
  input logic              cpu_irq,
  input logic              host_irq,
  input logic [DATA_W-1:0] in_db,
  input logic [DATA_W-1:0] out_db,
  input logic [DATA_W-1:0] in_cause_q,
  input logic [DATA_W-1:0] out_cause_q,
  input logic [DATA_W-1:0] in_mask,
  input logic [DATA_W-1:0] out_mask
);
  logic in_pend, out_pend;
  assign in_pend  = |(in_cause_q  & ~in_mask)  || (|in_db  && !in_mask[2]);
  assign out_pend = |(out_cause_q & ~out_mask) || (|out_db && !out_mask[2]);

  p_imsg_sets_evt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == ADDR_W'(1)) |=> in_cause_q[1]);

  p_omsg_sets_evt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == ADDR_W'(2)) |=> out_cause_q[0]);

  p_odb_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_we && host_addr == ADDR_W'(5)) |=> ((out_db & $past(out_db)) == $past(out_db)));

  p_idb_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_we && cpu_addr == ADDR_W'(4)) |=> ((in_db & $past(in_db)) == $past(in_db)));

  p_mask_host_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !cpu_we) |=> ($stable(in_mask) && $stable(out_mask)));

  p_cpu_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cpu_irq == $past(in_pend)));

  p_host_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (host_irq == $past(out_pend)));
endmodule

bind mbox_doorbell mbox_doorbell_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .host_we(host_we), .host_addr(host_addr), .cpu_irq(cpu_irq), .host_irq(host_irq),
  .in_db(in_db), .out_db(out_db), .in_cause_q(in_cause_q), .out_cause_q(out_cause_q),
  .in_mask(in_mask), .out_mask(out_mask)
);

// File: tb/tb_mbox_doorbell.sv
`timescale 1ns/1ps
module tb_mbox_doorbell;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_we = 1'b0, host_we = 1'b0, post_evt = 1'b0;
  logic [3:0] cpu_addr = '0, host_addr = '0;
  logic [31:0] cpu_wdata = '0, host_wdata = '0;
  logic [31:0] cpu_rdata, host_rdata;
  logic cpu_irq, host_irq;

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] m_im [2];
  logic [31:0] m_om [2];
  logic [31:0] m_idb = 0, m_odb = 0, m_iev = 0, m_oev = 0;
  logic [31:0] m_imsk = 32'hFFFF_FFFF, m_omsk = 32'hFFFF_FFFF;
  logic m_cirq = 1'b0, m_hirq = 1'b0;

  mbox_doorbell #(.DATA_W(32), .ADDR_W(4)) dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .post_evt(post_evt), .cpu_irq(cpu_irq), .host_irq(host_irq)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_im[0];
      4'd1: return m_im[1];
      4'd2: return m_om[0];
      4'd3: return m_om[1];
      4'd4: return m_idb;
      4'd5: return m_odb;
      4'd6: return m_iev | ((m_idb != 0) ? 32'h4 : 32'h0);
      4'd7: return m_imsk;
      4'd8: return m_oev | ((m_odb != 0) ? 32'h4 : 32'h0);
      4'd9: return m_omsk;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'd0, 4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4: return "R6";
      4'd5: return "R5";
      4'd6, 4'd8: return "R4";
      4'd7, 4'd9: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic model_step();
    logic [31:0] iv, ov, iclr, oclr;
    iv = m_read(4'd6);
    ov = m_read(4'd8);
    m_cirq = |(iv & ~m_imsk);
    m_hirq = |(ov & ~m_omsk);
    iclr = (cpu_we && cpu_addr == 6) ? (cpu_wdata & 32'h13) : 32'h0;
    oclr = (host_we && host_addr == 8) ? (host_wdata & 32'h3) : 32'h0;
    m_iev = m_iev & ~iclr;
    m_oev = m_oev & ~oclr;
    if (host_we && host_addr == 0) begin m_im[0] = host_wdata; m_iev[0] = 1'b1; end
    if (host_we && host_addr == 1) begin m_im[1] = host_wdata; m_iev[1] = 1'b1; end
    if (cpu_we && cpu_addr == 2) begin m_om[0] = cpu_wdata; m_oev[0] = 1'b1; end
    if (cpu_we && cpu_addr == 3) begin m_om[1] = cpu_wdata; m_oev[1] = 1'b1; end
    if (post_evt) m_iev[4] = 1'b1;
    if (cpu_we && cpu_addr == 4) m_idb = m_idb & ~cpu_wdata;
    if (host_we && host_addr == 4) m_idb = m_idb | host_wdata;
    if (host_we && host_addr == 5) m_odb = m_odb & ~host_wdata;
    if (cpu_we && cpu_addr == 5) m_odb = m_odb | cpu_wdata;
    if (cpu_we && cpu_addr == 7) m_imsk = cpu_wdata;
    if (cpu_we && cpu_addr == 9) m_omsk = cpu_wdata;
  endtask

  task automatic compare_all();
    check(tag_of(cpu_addr), cpu_rdata, m_read(cpu_addr));
    check(tag_of(host_addr), host_rdata, m_read(host_addr));
    check("R10 cpu_irq", {31'b0, cpu_irq}, {31'b0, m_cirq});
    check("R10 host_irq", {31'b0, host_irq}, {31'b0, m_hirq});
  endtask

  task automatic tick(input logic cw, input logic [3:0] ca, input logic [31:0] cd,
                      input logic hw, input logic [3:0] ha, input logic [31:0] hd,
                      input logic pe);
    cpu_we = cw; cpu_addr = ca; cpu_wdata = cd;
    host_we = hw; host_addr = ha; host_wdata = hd; post_evt = pe;
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m_im[0] = 0; m_im[1] = 0; m_om[0] = 0; m_om[1] = 0;
    cpu_addr = 4'd7; host_addr = 4'd9;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 in_mask", cpu_rdata, 32'hFFFF_FFFF);
    check("R1 out_mask", host_rdata, 32'hFFFF_FFFF);
    check("R1 irqs", {30'b0, cpu_irq, host_irq}, 32'h0);
    compare_all();
    cpu_addr = 4'd6; host_addr = 4'd5;
    #1;
    check("R1 in_evt", cpu_rdata, 32'h0);
    check("R1 out_db", host_rdata, 32'h0);

    tick(0, 1, 0, 1, 1, 32'hA5A5_0001, 0);
    check("R2 msg1 data", cpu_rdata, 32'hA5A5_0001);
    tick(0, 6, 0, 0, 0, 0, 0);
    check("R2 evt bit1", cpu_rdata, 32'h2);
    tick(1, 0, 32'hDEAD_BEEF, 0, 0, 0, 0);
    check("R2 cpu write ignored", host_rdata, 32'h0);

    tick(1, 2, 32'h1234_5678, 1, 3, 32'h5555_5555, 0);
    check("R3 host write ignored", host_rdata, 32'h0);
    tick(0, 2, 0, 0, 8, 0, 0);
    check("R3 msg0 data", cpu_rdata, 32'h1234_5678);
    check("R3 evt bit0", host_rdata, 32'h1);

    tick(1, 7, 32'hFFFF_FFFD, 0, 8, 0, 0);
    check("R10 irq one cycle later", {31'b0, cpu_irq}, 32'h0);
    tick(0, 6, 0, 0, 8, 0, 0);
    check("R10 cpu_irq up", {31'b0, cpu_irq}, 32'h1);

    tick(1, 6, 32'hFFFF_FFFF, 1, 6, 32'hFFFF_FFFF, 0);
    check("R4 cpu clears in evt", cpu_rdata, 32'h0);
    tick(1, 8, 32'hFFFF_FFFF, 0, 8, 0, 0);
    check("R4 cpu cannot clear out evt", host_rdata, 32'h1);
    tick(0, 0, 0, 1, 8, 32'h1, 0);
    check("R4 host clears out evt", host_rdata, 32'h0);
    tick(0, 0, 0, 0, 8, 0, 0);
    check("R10 cpu_irq down", {31'b0, cpu_irq}, 32'h0);

    tick(0, 4, 0, 1, 4, 32'h3, 0);
    check("R6 host sets in_db", cpu_rdata, 32'h3);
    tick(1, 4, 32'h1, 0, 6, 0, 0);
    check("R6 cpu clears in_db", cpu_rdata, 32'h2);
    check("R7 bit2 while db nonzero", host_rdata, 32'h4);
    tick(1, 6, 32'h4, 0, 6, 0, 0);
    check("R7 evt write cannot clear", cpu_rdata, 32'h4);
    tick(1, 4, 32'h2, 0, 6, 0, 0);
    check("R7 bit2 drops at zero", host_rdata, 32'h0);
    tick(1, 4, 32'h10, 1, 4, 32'h10, 0);
    check("R6 set wins", cpu_rdata, 32'h10);
    tick(1, 4, 32'hFFFF_FFFF, 0, 4, 0, 0);

    tick(1, 5, 32'h8000_0001, 0, 5, 0, 0);
    check("R5 cpu sets out_db", host_rdata, 32'h8000_0001);
    tick(1, 5, 32'h8000_0000, 1, 5, 32'h8000_0001, 0);
    check("R5 set wins", host_rdata, 32'h8000_0000);
    tick(1, 9, 32'hFFFF_FFFB, 0, 8, 0, 0);
    check("R7 out bit2", host_rdata, 32'h4);
    check("R9 masked host_irq", {31'b0, host_irq}, 32'h0);
    tick(0, 0, 0, 0, 8, 0, 0);
    check("R10 host_irq up", {31'b0, host_irq}, 32'h1);
    tick(0, 0, 0, 1, 5, 32'hFFFF_FFFF, 0);
    tick(0, 0, 0, 0, 8, 0, 0);
    check("R10 host_irq down", {31'b0, host_irq}, 32'h0);

    tick(1, 6, 32'h10, 0, 0, 0, 1);
    check("R8 post set wins", cpu_rdata, 32'h10);
    tick(1, 6, 32'h10, 0, 0, 0, 0);
    check("R8 post cleared", cpu_rdata, 32'h0);

    tick(0, 7, 0, 1, 7, 32'h0, 0);
    check("R9 host mask write ignored", cpu_rdata, 32'hFFFF_FFFD);
    tick(0, 12, 0, 0, 15, 0, 0);
    check("R11 cpu unmapped", cpu_rdata, 32'h0);
    check("R11 host unmapped", host_rdata, 32'h0);

    for (int k = 0; k < 4000; k++) begin
      logic [31:0] cd, hd;
      cd = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : $urandom;
      hd = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : $urandom;
      tick(1'($urandom_range(0, 1)), 4'($urandom_range(0, 12)), cd,
           1'($urandom_range(0, 1)), 4'($urandom_range(0, 12)), hd,
           ($urandom_range(0, 7) == 0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule